// File: doc/BRIEF.md
# Sum-of-Products Logic Plane

This block is a configurable two-level logic plane. Ten external inputs and eight fed-back result lines form eighteen array signals. Each signal reaches every product term in both true and inverted form, and a stored fuse bit decides whether that literal takes part in the term. Each of the eight outputs owns a fixed group of eight product terms. The first term of each group gives that output's enable signal. The remaining seven terms are ORed into the output's sum. Only the AND connections can be programmed; the grouping of terms into outputs is fixed.

The fuse map is loaded one bit per clock through a serial port while `cfg_en` is high. The bits go into a shadow register, so the map that is currently active keeps driving the logic during a load. On the first clock edge where `cfg_en` is seen low after being high, the whole shadow is copied into the active map in one step. Each sum output is captured into a feedback register on every clock edge. That register feeds the array on the next cycle, so latches and state machines can be built from the plane itself. This interface carries no flow control: `cfg_en` and `cfg_bit` are plain control pins sampled on every edge.

Top module: `pal_sop_plane`

## Requirements
- R1: While `rst_n` is low, the active map, the shadow map and the feedback register are cleared. With the active map all zero, every term is true, so `sum_o` and `oe_o` both read 8'hFF after reset.
- R2: On every clock edge where `cfg_en` is high, one `cfg_bit` is shifted into the shadow. Bits are sent in ascending fuse index order, so the first bit sent lands at index 0 after 2304 shifts.
- R3: The active map changes only on the first edge where `cfg_en` is low after an edge where it was high. At that edge the active map takes the shadow contents, and the outputs follow the new map from the next cycle on.
- R4: While a load is in progress, `sum_o` and `oe_o` are computed only from the previously active map. Partially shifted bits have no effect on them.
- R5: Fuse index = (output*8 + term)*36 + column. Column 2*s selects array signal s in true form and column 2*s+1 selects it inverted. Signals 0..9 are `in_i[0..9]` and signals 10..17 are the feedback of outputs 0..7. A fuse bit of 1 connects the literal.
- R6: A product term with no connected literal evaluates to 1.
- R7: A product term that connects both the true and the inverted form of the same signal evaluates to 0.
- R8: `sum_o[o]` is the OR of terms 1..7 of output o. Term 0 never contributes to the sum.
- R9: `oe_o[o]` equals term 0 of output o.
- R10: The feedback signal of output o is `sum_o[o]` as sampled at the previous clock edge. A term that uses feedback therefore sees the result one cycle late.
- R11: For arbitrary fuse maps and input vectors, both outputs match a sum-of-products evaluation of the active map with the feedback values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | High while fuse bits are being shifted in; its fall commits the map |
| cfg_bit | input | 1 | Serial fuse bit, sampled while `cfg_en` is high |
| in_i | input | 10 | Primary array inputs |
| sum_o | output | 8 | Per-output OR of terms 1..7 |
| oe_o | output | 8 | Per-output enable term (term 0) |

## Verification
Two things can happen in the same cycle: a new map is being shifted into the shadow while the active map is still evaluating live inputs and feedback. Also, the commit edge coincides with a feedback capture that must still use the old map. The bench provokes this by loading each new map while the plane holds state from the previous one. Part-way through every load it compares the outputs against a reference that knows only the old map. Right after the commit edge it compares them against the new map, with feedback that was captured under the old one.

// File: rtl/pal_plane_pkg.sv
package pal_plane_pkg;
  localparam int unsigned PAL_N_IN   = 10;
  localparam int unsigned PAL_N_OUT  = 8;
  localparam int unsigned PAL_N_TERM = 8;
endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
  parameter int unsigned TOTAL = 2304
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  output logic [TOTAL-1:0] map_q
);
  logic [TOTAL-1:0] shadow_q;
  logic             en_d_q;
  logic             commit;

  assign commit = en_d_q & ~cfg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      map_q    <= '0;
      en_d_q   <= 1'b0;
    end else begin
      en_d_q <= cfg_en;
      if (cfg_en) shadow_q <= {cfg_bit, shadow_q[TOTAL-1:1]};
      if (commit) map_q <= shadow_q;
    end
  end

  // live map untouched while bits are still arriving
  assert_map_frozen_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> $stable(map_q));
  // outside a load and its trailing commit edge the map does not move
  assert_map_only_on_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !en_d_q) |=> $stable(map_q));
endmodule

// File: rtl/pal_product_term.sv
module pal_product_term #(
  parameter int unsigned N_SIG = 18,
  localparam int unsigned N_COL = 2 * N_SIG
) (
  input  logic [N_SIG-1:0] lit_i,
  input  logic [N_COL-1:0] fuse_i,
  output logic             term_o
);
  logic [N_SIG-1:0] miss;

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    assign miss[s] = (fuse_i[2*s] & ~lit_i[s]) | (fuse_i[2*s+1] & lit_i[s]);
  end

  assign term_o = ~|miss;
endmodule

// File: rtl/pal_or_group.sv
module pal_or_group #(
  parameter int unsigned N_SIG  = 18,
  parameter int unsigned N_TERM = 8,
  localparam int unsigned N_COL = 2 * N_SIG,
  localparam int unsigned G_BITS = N_TERM * N_COL
) (
  input  logic [N_SIG-1:0]  lit_i,
  input  logic [G_BITS-1:0] fuse_i,
  output logic              sum_o,
  output logic              oe_o
);
  logic [N_TERM-1:0] term;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pal_product_term #(.N_SIG(N_SIG)) u_term (
      .lit_i  (lit_i),
      .fuse_i (fuse_i[t*N_COL +: N_COL]),
      .term_o (term[t])
    );
  end

  assign oe_o  = term[0];
  assign sum_o = |term[N_TERM-1:1];
endmodule

// File: rtl/pal_sop_plane.sv
module pal_sop_plane #(
  parameter int unsigned N_IN   = pal_plane_pkg::PAL_N_IN,
  parameter int unsigned N_OUT  = pal_plane_pkg::PAL_N_OUT,
  parameter int unsigned N_TERM = pal_plane_pkg::PAL_N_TERM
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic            cfg_bit,
  input  logic [N_IN-1:0] in_i,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_o
);
  localparam int unsigned N_SIG  = N_IN + N_OUT;
  localparam int unsigned N_COL  = 2 * N_SIG;
  localparam int unsigned G_BITS = N_TERM * N_COL;
  localparam int unsigned TOTAL  = N_OUT * G_BITS;

  logic [TOTAL-1:0] map_q;
  logic [N_OUT-1:0] fb_q;
  logic [N_SIG-1:0] lit;

  assign lit = {fb_q, in_i};

  pal_fuse_store #(.TOTAL(TOTAL)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .map_q   (map_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fb_q <= '0;
    else        fb_q <= sum_o;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_COL-1:0] en_fuse;
    logic [N_SIG-1:0] en_t;
    logic [N_SIG-1:0] en_c;

    pal_or_group #(.N_SIG(N_SIG), .N_TERM(N_TERM)) u_group (
      .lit_i  (lit),
      .fuse_i (map_q[o*G_BITS +: G_BITS]),
      .sum_o  (sum_o[o]),
      .oe_o   (oe_o[o])
    );

    assign en_fuse = map_q[o*G_BITS +: N_COL];
    for (genvar s = 0; s < N_SIG; s++) begin : g_pol
      assign en_t[s] = en_fuse[2*s];
      assign en_c[s] = en_fuse[2*s+1];
    end

    assert_empty_term_true_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_fuse == '0) |-> oe_o[o]);
    assert_conflict_term_false_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(en_t & en_c)) |-> !oe_o[o]);
  end

  assert_feedback_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (fb_q == $past(sum_o)));
endmodule

// File: tb/tb_pal_sop_plane.sv
module tb_pal_sop_plane;
  localparam int NI = 10;
  localparam int NO = 8;
  localparam int NT = 8;
  localparam int NC = 2 * (NI + NO);
  localparam int TOTAL = NO * NT * NC;
  localparam logic [9:0] VEC [0:11] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA,
    10'h001, 10'h200, 10'h0F0, 10'h30F, 10'h18C, 10'h063, 10'h3C3, 10'h124};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic cfg_bit = 1'b0;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] sum_o, oe_o;
  logic [TOTAL-1:0] active_m, pend_m, work_m;
  logic [NO-1:0] fb_m;
  logic en_d_m;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pal_sop_plane dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .in_i(din), .sum_o(sum_o), .oe_o(oe_o)
  );

  function automatic logic ref_term(input logic [TOTAL-1:0] m, input int o, input int t,
                                    input logic [NI-1:0] x, input logic [NO-1:0] f);
    int base = (o * NT + t) * NC;
    for (int s = 0; s < NI + NO; s++) begin
      logic v = (s < NI) ? x[s] : f[s-NI];
      if (m[base + 2*s] && !v) return 1'b0;
      if (m[base + 2*s + 1] && v) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [NO-1:0] ref_sum(input logic [TOTAL-1:0] m,
                                            input logic [NI-1:0] x, input logic [NO-1:0] f);
    logic [NO-1:0] r = '0;
    for (int o = 0; o < NO; o++)
      for (int t = 1; t < NT; t++) r[o] = r[o] | ref_term(m, o, t, x, f);
    return r;
  endfunction

  function automatic logic [NO-1:0] ref_oe(input logic [TOTAL-1:0] m,
                                           input logic [NI-1:0] x, input logic [NO-1:0] f);
    logic [NO-1:0] r;
    for (int o = 0; o < NO; o++) r[o] = ref_term(m, o, 0, x, f);
    return r;
  endfunction

  // requirement-level model: feedback capture and commit timing
  always @(posedge clk) begin
    if (!rst_n) begin
      fb_m <= '0;
      active_m <= '0;
      en_d_m <= 1'b0;
    end else begin
      fb_m <= ref_sum(active_m, din, fb_m);
      en_d_m <= cfg_en;
      if (en_d_m && !cfg_en) active_m <= pend_m;
    end
  end

  task automatic chk(input string req, input string what, input logic [NO-1:0] got,
                     input logic [NO-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic chk_model(input string req);
    chk(req, "sum_o", sum_o, ref_sum(active_m, din, fb_m));
    chk(req, "oe_o", oe_o, ref_oe(active_m, din, fb_m));
  endtask

  task automatic apply(input logic [NI-1:0] x);
    @(negedge clk);
    din = x;
    #5;
  endtask

  // R2 ascending index order; R4 checked part-way through the load
  task automatic load(input logic [TOTAL-1:0] m);
    pend_m = m;
    for (int i = 0; i < TOTAL; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_bit = m[i];
      if (i % 768 == 300) begin
        #5;
        chk_model("R4");
      end
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_bit = 1'b0;
    @(negedge clk);
    #5;
    chk_model("R3");
  endtask

  function automatic int fidx(input int o, input int t, input int c);
    return (o * NT + t) * NC + c;
  endfunction

  task automatic clear_term(input int o, input int t);
    for (int c = 0; c < NC; c++) work_m[fidx(o, t, c)] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1", "sum_o after reset", sum_o, 8'hFF);
    chk("R6", "oe_o after reset", oe_o, 8'hFF);

    // directed map: every term killed by in0 & ~in0 (R7), then a few programmed terms
    work_m = '0;
    for (int o = 0; o < NO; o++)
      for (int t = 0; t < NT; t++) begin
        work_m[fidx(o, t, 0)] = 1'b1;
        work_m[fidx(o, t, 1)] = 1'b1;
      end
    clear_term(0, 0); work_m[fidx(0, 0, 2)] = 1'b1;   // oe0 = in1
    clear_term(0, 1); work_m[fidx(0, 1, 0)] = 1'b1;   // in0
    clear_term(0, 2); work_m[fidx(0, 2, 5)] = 1'b1;   // ~in2
    clear_term(1, 3);                                 // empty term -> sum1 = 1
    clear_term(2, 1); work_m[fidx(2, 1, 24)] = 1'b1;  // fb2
    work_m[fidx(2, 1, 9)] = 1'b1;                     // & ~in4
    clear_term(2, 2); work_m[fidx(2, 2, 6)] = 1'b1;   // in3
    clear_term(3, 0);                                 // oe3 = 1
    load(work_m);

    apply(10'b0000010000);
    chk("R8", "sum_o clear latch", sum_o, 8'b0000_0011);
    chk("R7", "oe_o killed terms", oe_o, 8'b0000_1000);
    apply(10'b0000000000);
    chk("R10", "sum_o latch stays clear", sum_o, 8'b0000_0011);
    apply(10'b0000001000);
    chk("R5", "sum_o latch set via in3", sum_o, 8'b0000_0111);
    apply(10'b0000000000);
    chk("R10", "sum_o latch holds via feedback", sum_o, 8'b0000_0111);
    apply(10'b0000000100);
    chk("R8", "sum_o in2 blocks output 0", sum_o, 8'b0000_0110);
    apply(10'b0000000110);
    chk("R8", "sum_o enable term excluded", sum_o, 8'b0000_0110);
    chk("R9", "oe_o follows in1", oe_o, 8'b0000_1001);
    apply(10'b0000010000);
    chk("R10", "sum_o latch cleared by in4", sum_o, 8'b0000_0011);
    chk("R6", "sum_o empty term output 1", {7'b0, sum_o[1]}, 8'h01);

    // R11: sparse random maps walked over the vector table
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < TOTAL; i++) work_m[i] = ($urandom_range(0, 23) == 0);
      load(work_m);
      for (int v = 0; v < 12; v++) begin
        apply(VEC[v]);
        chk_model("R11");
      end
    end

    // R1: a later reset clears the active map again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1", "sum_o after second reset", sum_o, 8'hFF);
    chk("R1", "oe_o after second reset", oe_o, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule